// File: doc/BRIEF.md
# Branch Resolution and Target Unit

This unit executes branch operations that have already been decoded, on behalf of a 64-bit load/store processor. Each valid cycle it receives the branch form, the absolute-address and link flags, the 5-bit branch-options field, a 5-bit condition-bit selector, the displacement, the current instruction address, the 32-bit condition register and a mode flag that selects 64-bit or 32-bit addressing. In the same cycle, through combinational logic, it returns the address of the next instruction and a taken flag.

The unit holds three 64-bit registers: the return-address (link) register, the loop counter and a spare target register. On the clock edge that ends a valid cycle it may decrement the counter and write a return address. A separate load port lets the surrounding pipeline place values into any of the three registers. The hint field that some branch forms carry is not used.

Top module: `brx_unit`

## Requirements
- R1: kind_i selects the form: 0 unconditional immediate, 1 conditional immediate, 2 conditional to link register, 3 conditional to counter, 4 conditional to target register. Form 0 always branches. Its offset is disp_i[23:0] followed by two zero bits and sign-extended. Form 1 uses disp_i[13:0] in the same way. If abs_i=1 the target is the offset itself; otherwise it is cia_i plus the offset.
- R2: On a valid cycle with link_i=1 and kind_i in 0..4, the link register receives cia_i+4, whether or not the branch is taken.
- R3: BO bit n corresponds to bo_i[4-n]. Forms 1, 2 and 4 decrement the counter by one on a valid cycle when bo_i[2]=0.
- R4: The count test passes when bo_i[2]=1, or when (the counter value after the decrement is nonzero) XOR bo_i[1] is 1.
- R5: With mode64_i=1 the count test looks at all 64 counter bits. With mode64_i=0 it looks only at bits 31:0.
- R6: The condition test passes when bo_i[4]=1, or when cr_i[31-bi_i] equals bo_i[3]. Forms 1 to 4 branch only when both tests pass, and taken_o is 0 when valid_i is 0.
- R7: Forms 2 and 4 branch to the link register or the target register with bits 1:0 cleared. Form 2 with link_i=1 uses the link value held before this cycle's write.
- R8: Form 3 never changes the counter, applies only the condition test, and branches to the counter with bits 1:0 cleared.
- R9: When no branch is taken, nia_o is cia_i+4. With mode64_i=0, bits 63:32 of nia_o and of the written link value are zero.
- R10: When valid_i is 0, no branch updates any register.
- R11: ld_en_i writes ld_data_i to the register chosen by ld_sel_i (0 link, 1 counter, 2 target). A branch update of the same register in the same cycle takes priority over the load.
- R12: A synchronous active-high rst clears all three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| valid_i | input | 1 | a branch operation is present |
| kind_i | input | 3 | branch form code |
| abs_i | input | 1 | immediate target is absolute |
| link_i | input | 1 | write the return address |
| bo_i | input | 5 | branch-options field |
| bi_i | input | 5 | condition-bit selector |
| disp_i | input | 24 | displacement (14 low bits for form 1) |
| cia_i | input | 64 | current instruction address |
| cr_i | input | 32 | condition register |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| ld_en_i | input | 1 | register load strobe |
| ld_sel_i | input | 2 | register chosen by the load |
| ld_data_i | input | 64 | load value |
| nia_o | output | 64 | next instruction address |
| taken_o | output | 1 | branch taken |
| lr_o | output | 64 | link register |
| ctr_o | output | 64 | counter register |
| tar_o | output | 64 | target register |

## Verification
The assertions rely on three properties of the inputs. cia_i is word-aligned, kind_i stays within 0..4 whenever valid_i is high, and in 32-bit mode cia_i has its upper half already zero. The alignment check on taken register targets and the sequential-address check depend on these. The stimulus generates only aligned addresses and legal form codes, and it clears the upper half of cia_i whenever mode64_i is low. It drives forms, options, condition bits and register loads at random, mixed with directed cases: a counter that wraps to zero only in its low half, a link-register branch that also links, and a load that collides with a branch update.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [2:0] {
    BK_IMM  = 3'd0,
    BK_CIMM = 3'd1,
    BK_CLR  = 3'd2,
    BK_CCTR = 3'd3,
    BK_CTAR = 3'd4
  } brx_kind_e;

  localparam logic [1:0] SEL_LR  = 2'd0;
  localparam logic [1:0] SEL_CTR = 2'd1;
  localparam logic [1:0] SEL_TAR = 2'd2;
  localparam int         NREG    = 3;
endpackage

// File: rtl/brx_test.sv
// Counter decrement, count test and condition-bit test.
module brx_test #(
  parameter int XLEN = 64,
  parameter int CRW  = 32,
  localparam int HALF = XLEN / 2,
  localparam int BIW  = $clog2(CRW)
) (
  input  logic [2:0]      kind,
  input  logic [4:0]      bo,
  input  logic [BIW-1:0]  bi,
  input  logic [CRW-1:0]  cr,
  input  logic [XLEN-1:0] ctr,
  input  logic            mode64,
  output logic            dec_en,
  output logic [XLEN-1:0] ctr_next,
  output logic            take
);
  import brx_pkg::*;

  logic [CRW-1:0] cr_rev;
  logic           nz, cnt_ok, cond_ok, uses_cnt, legal;
  brx_kind_e      k;

  always_comb begin
    for (int i = 0; i < CRW; i++) cr_rev[i] = cr[CRW-1-i];
  end

  always_comb begin
    k        = brx_kind_e'(kind);
    uses_cnt = (k == BK_CIMM) || (k == BK_CLR) || (k == BK_CTAR);
    legal    = uses_cnt || (k == BK_IMM) || (k == BK_CCTR);
    dec_en   = uses_cnt && !bo[2];
    ctr_next = dec_en ? ctr - XLEN'(1) : ctr;
    nz       = mode64 ? (|ctr_next) : (|ctr_next[HALF-1:0]);
    cnt_ok   = !uses_cnt || bo[2] || (nz ^ bo[1]);
    cond_ok  = bo[4] || (cr_rev[bi] == bo[3]);
    if (k == BK_IMM) take = 1'b1;
    else             take = legal && cnt_ok && cond_ok;
  end
endmodule

// File: rtl/brx_addr.sv
// Target selection and next-address / return-address formation.
module brx_addr #(
  parameter int XLEN = 64,
  parameter int LIW  = 24,
  parameter int BDW  = 14,
  localparam int HALF = XLEN / 2
) (
  input  logic [2:0]      kind,
  input  logic            abs_f,
  input  logic [LIW-1:0]  disp,
  input  logic [XLEN-1:0] cia,
  input  logic [XLEN-1:0] lr,
  input  logic [XLEN-1:0] ctr,
  input  logic [XLEN-1:0] tar,
  input  logic            take,
  input  logic            mode64,
  output logic [XLEN-1:0] nia,
  output logic [XLEN-1:0] ret
);
  import brx_pkg::*;

  logic [XLEN-1:0] off_li, off_bd, off, rel_tgt, tgt, raw_nia, seq;

  function automatic logic [XLEN-1:0] fit(input logic [XLEN-1:0] v, input logic m64);
    return m64 ? v : {{HALF{1'b0}}, v[HALF-1:0]};
  endfunction

  always_comb begin
    off_li  = {{(XLEN-LIW-2){disp[LIW-1]}}, disp, 2'b00};
    off_bd  = {{(XLEN-BDW-2){disp[BDW-1]}}, disp[BDW-1:0], 2'b00};
    off     = (brx_kind_e'(kind) == BK_IMM) ? off_li : off_bd;
    rel_tgt = abs_f ? off : cia + off;
    seq     = cia + XLEN'(4);
    case (brx_kind_e'(kind))
      BK_CLR:  tgt = {lr[XLEN-1:2], 2'b00};
      BK_CCTR: tgt = {ctr[XLEN-1:2], 2'b00};
      BK_CTAR: tgt = {tar[XLEN-1:2], 2'b00};
      default: tgt = rel_tgt;
    endcase
    raw_nia = take ? tgt : seq;
    nia     = fit(raw_nia, mode64);
    ret     = fit(seq, mode64);
  end
endmodule

// File: rtl/brx_regs.sv
// Bank of special-purpose registers, one write port each.
module brx_regs #(
  parameter int XLEN = 64,
  parameter int NR   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NR-1:0]            we,
  input  logic [NR-1:0][XLEN-1:0]  wd,
  output logic [NR-1:0][XLEN-1:0]  q
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q[g] <= '0;
      else if (we[g]) q[g] <= wd[g];
    end
  end
endmodule

// File: rtl/brx_unit.sv
module brx_unit #(
  parameter int XLEN = 64,
  parameter int CRW  = 32,
  parameter int LIW  = 24,
  parameter int BDW  = 14,
  localparam int BIW = $clog2(CRW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [2:0]      kind_i,
  input  logic            abs_i,
  input  logic            link_i,
  input  logic [4:0]      bo_i,
  input  logic [BIW-1:0]  bi_i,
  input  logic [LIW-1:0]  disp_i,
  input  logic [XLEN-1:0] cia_i,
  input  logic [CRW-1:0]  cr_i,
  input  logic            mode64_i,
  input  logic            ld_en_i,
  input  logic [1:0]      ld_sel_i,
  input  logic [XLEN-1:0] ld_data_i,
  output logic [XLEN-1:0] nia_o,
  output logic            taken_o,
  output logic [XLEN-1:0] lr_o,
  output logic [XLEN-1:0] ctr_o,
  output logic [XLEN-1:0] tar_o
);
  import brx_pkg::*;

  logic                          dec_en, take, legal, br_lr, br_ctr;
  logic [XLEN-1:0]               ctr_next, ret;
  logic [NREG-1:0]               we;
  logic [NREG-1:0][XLEN-1:0]     wd, q;

  brx_test #(.XLEN(XLEN), .CRW(CRW)) u_test (
    .kind(kind_i), .bo(bo_i), .bi(bi_i), .cr(cr_i), .ctr(q[SEL_CTR]),
    .mode64(mode64_i), .dec_en(dec_en), .ctr_next(ctr_next), .take(take)
  );

  brx_addr #(.XLEN(XLEN), .LIW(LIW), .BDW(BDW)) u_addr (
    .kind(kind_i), .abs_f(abs_i), .disp(disp_i), .cia(cia_i),
    .lr(q[SEL_LR]), .ctr(q[SEL_CTR]), .tar(q[SEL_TAR]), .take(take),
    .mode64(mode64_i), .nia(nia_o), .ret(ret)
  );

  always_comb begin
    legal  = kind_i <= 3'd4;
    br_lr  = valid_i && link_i && legal;
    br_ctr = valid_i && dec_en;
    for (int r = 0; r < NREG; r++) begin
      we[r] = ld_en_i && (ld_sel_i == 2'(r));
      wd[r] = ld_data_i;
    end
    if (br_lr) begin
      we[SEL_LR] = 1'b1;
      wd[SEL_LR] = ret;
    end
    if (br_ctr) begin
      we[SEL_CTR] = 1'b1;
      wd[SEL_CTR] = ctr_next;
    end
  end

  brx_regs #(.XLEN(XLEN), .NR(NREG)) u_regs (
    .clk(clk), .rst(rst), .we(we), .wd(wd), .q(q)
  );

  assign taken_o = valid_i && take;
  assign lr_o    = q[SEL_LR];
  assign ctr_o   = q[SEL_CTR];
  assign tar_o   = q[SEL_TAR];
endmodule

// File: rtl/brx_chk.sv
module brx_chk (
  input logic        clk,
  input logic        rst,
  input logic        valid_i,
  input logic [2:0]  kind_i,
  input logic        link_i,
  input logic        mode64_i,
  input logic [63:0] cia_i,
  input logic        ld_en_i,
  input logic [1:0]  ld_sel_i,
  input logic [63:0] nia_o,
  input logic        taken_o,
  input logic [63:0] lr_o,
  input logic [63:0] ctr_o
);
  logic [63:0] seq_a;
  always_comb begin
    seq_a = cia_i + 64'd4;
    if (!mode64_i) seq_a[63:32] = '0;
  end

  // R12
  reset_clear_chk: assert property (@(posedge clk) rst |=> (lr_o == '0 && ctr_o == '0));
  // R10
  lr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !(ld_en_i && ld_sel_i == 2'd0)) |=> $stable(lr_o));
  // R10
  ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !(ld_en_i && ld_sel_i == 2'd1)) |=> $stable(ctr_o));
  // R8
  cctr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && kind_i == 3'd3 && !(ld_en_i && ld_sel_i == 2'd1)) |=> $stable(ctr_o));
  // R2
  link_write_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && link_i && kind_i <= 3'd4) |=> lr_o == $past(seq_a));
  // R1
  imm_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && kind_i == 3'd0) |-> taken_o);
  // R9
  seq_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && kind_i <= 3'd4 && !taken_o) |-> nia_o == seq_a);
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !mode64_i) |-> nia_o[63:32] == '0);
  // R7
  align_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o && kind_i >= 3'd2) |-> nia_o[1:0] == 2'b00);
endmodule

bind brx_unit brx_chk u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .kind_i(kind_i), .link_i(link_i),
  .mode64_i(mode64_i), .cia_i(cia_i), .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i),
  .nia_o(nia_o), .taken_o(taken_o), .lr_o(lr_o), .ctr_o(ctr_o)
);

// File: tb/test_brx_unit.sv
`timescale 1ns/1ps
module test_brx_unit;
  logic        clk = 1'b0, rst = 1'b1;
  logic        valid_i = 0, abs_i = 0, link_i = 0, mode64_i = 1, ld_en_i = 0;
  logic [2:0]  kind_i = 0;
  logic [4:0]  bo_i = 0, bi_i = 0;
  logic [23:0] disp_i = 0;
  logic [63:0] cia_i = 0, ld_data_i = 0;
  logic [31:0] cr_i = 0;
  logic [1:0]  ld_sel_i = 0;
  logic [63:0] nia_o, lr_o, ctr_o, tar_o;
  logic        taken_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit [63:0] m_lr = 0, m_ctr = 0, m_tar = 0;

  always #2.5 clk = ~clk;

  brx_unit i_brx_unit (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [63:0] fit(bit [63:0] v, bit m64);
    return m64 ? v : {32'b0, v[31:0]};
  endfunction

  // One cycle: drive at negedge, compare combinational outputs, then registers.
  task automatic cyc(bit v, int k, bit aa, bit lk, bit [4:0] bo, bit [4:0] bi,
                     bit [23:0] d, bit [63:0] cia, bit [31:0] cr, bit m64,
                     bit le = 0, bit [1:0] ls = 0, bit [63:0] ldd = 0);
    bit dec, nz, cok, qok, tk;
    bit [63:0] c1, tgt, nia;
    bit signed [25:0] li;
    bit signed [15:0] bd;
    longint off;
    valid_i = v; kind_i = 3'(k); abs_i = aa; link_i = lk; bo_i = bo; bi_i = bi;
    disp_i = d; cia_i = cia; cr_i = cr; mode64_i = m64;
    ld_en_i = le; ld_sel_i = ls; ld_data_i = ldd;
    #1;
    dec = (k == 1 || k == 2 || k == 4) && !bo[2];
    c1  = dec ? m_ctr - 1 : m_ctr;
    nz  = m64 ? (c1 != 0) : (c1[31:0] != 0);
    cok = (k == 0 || k == 3) ? 1'b1 : (bo[2] || (nz ^ bo[1]));
    qok = (k == 0) ? 1'b1 : (bo[4] || (cr[31 - bi] == bo[3]));
    tk  = (k <= 4) && cok && qok;
    li  = {d, 2'b00};
    bd  = {d[13:0], 2'b00};
    off = (k == 0) ? longint'(li) : longint'(bd);
    case (k)
      2: tgt = m_lr & ~64'd3;
      3: tgt = m_ctr & ~64'd3;
      4: tgt = m_tar & ~64'd3;
      default: tgt = aa ? 64'(off) : cia + 64'(off);
    endcase
    nia = fit(tk ? tgt : cia + 4, m64);
    if (v) begin
      chk("R6 taken", {63'b0, taken_o}, {63'b0, tk});
      chk(!tk ? "R9 nia" : (k <= 1 ? "R1 nia" : (k == 3 ? "R8 nia" : "R7 nia")), nia_o, nia);
    end else chk("R10 taken", {63'b0, taken_o}, 64'd0);
    @(posedge clk);
    if (v && lk && k <= 4) m_lr = fit(cia + 4, m64);
    else if (le && ls == 0) m_lr = ldd;
    if (v && dec) m_ctr = c1;
    else if (le && ls == 1) m_ctr = ldd;
    if (le && ls == 2) m_tar = ldd;
    @(negedge clk);
    chk("R2 lr", lr_o, m_lr);
    chk("R3 ctr", ctr_o, m_ctr);
    chk("R11 tar", tar_o, m_tar);
  endtask

  task automatic load(bit [1:0] s, bit [63:0] val);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, s, val);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    chk("R12 lr", lr_o, 0); chk("R12 ctr", ctr_o, 0); chk("R12 tar", tar_o, 0);
    // R11 loads
    load(0, 64'h1000_0000_0000_0123);
    load(1, 64'd3);
    load(2, 64'hFFFF_FFFF_FFFF_FFF7);
    // R1 relative forward, backward, absolute with link (R2)
    cyc(1, 0, 0, 0, 0, 0, 24'h000010, 64'h2000, 0, 1);
    cyc(1, 0, 0, 0, 0, 0, 24'hFFFFFF, 64'h2000, 0, 1);
    cyc(1, 0, 1, 1, 0, 0, 24'h800000, 64'h4000, 0, 1);
    // R6 condition only: bo=10100 always; cr bit 0 tests
    cyc(1, 1, 0, 0, 5'b10100, 0, 24'h000100, 64'h8000, 0, 1);
    cyc(1, 1, 0, 0, 5'b01100, 5'd0, 24'h003FFF, 64'h8000, 32'h8000_0000, 1);
    cyc(1, 1, 0, 1, 5'b00100, 5'd31, 24'h000040, 64'h8000, 32'h0000_0001, 1);
    // R3/R4 count loop: decrement, branch while nonzero
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 5'b10000, 0, 24'h20, 64'h9000, 0, 1);
    cyc(1, 1, 0, 0, 5'b10010, 0, 24'h20, 64'h9000, 0, 1); // R4 branch when zero
    // R5 low-half wrap
    load(1, 64'h0000_0001_0000_0001);
    cyc(1, 1, 0, 0, 5'b10000, 0, 24'h20, 64'h9000, 0, 0);
    load(1, 64'h0000_0001_0000_0001);
    cyc(1, 1, 0, 0, 5'b10000, 0, 24'h20, 64'h9000, 0, 1);
    // R7 link-register branch that also links
    load(0, 64'h0000_0000_0000_5557);
    cyc(1, 2, 0, 1, 5'b10100, 0, 0, 64'hA000, 0, 1);
    cyc(1, 4, 0, 0, 5'b10100, 0, 0, 64'hA000, 0, 0);
    // R8 counter form never decrements
    load(1, 64'h0000_0000_0000_0777);
    cyc(1, 3, 0, 0, 5'b10000, 0, 0, 64'hA000, 0, 1);
    // R10 invalid cycle with a decrementing form
    cyc(0, 1, 0, 1, 5'b10000, 0, 24'h20, 64'hB000, 0, 1);
    // R11 collision: branch wins link and counter
    cyc(1, 1, 0, 1, 5'b10000, 0, 24'h20, 64'hC000, 0, 1, 1, 0, 64'hDEAD);
    cyc(1, 1, 0, 0, 5'b10000, 0, 24'h20, 64'hC000, 0, 1, 1, 1, 64'hBEEF);
    // random mix
    for (int i = 0; i < 400; i++) begin
      bit m = $urandom_range(0, 1);
      bit [63:0] a = {$urandom, $urandom} & ~64'd3;
      if (!m) a[63:32] = 0;
      if ($urandom_range(0, 7) == 0)
        load(2'($urandom_range(0, 2)), {$urandom, $urandom});
      else
        cyc($urandom_range(0, 7) != 0, $urandom_range(0, 4), 1'($urandom),
            1'($urandom), 5'($urandom), 5'($urandom), 24'($urandom), a,
            $urandom, m, $urandom_range(0, 5) == 0, 2'($urandom_range(0, 2)),
            {$urandom, $urandom});
    end
    // R12 reset mid-run
    rst = 1; @(negedge clk); rst = 0;
    m_lr = 0; m_ctr = 0; m_tar = 0;
    chk("R12 lr", lr_o, 0); chk("R12 ctr", ctr_o, 0); chk("R12 tar", tar_o, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule